// File: doc/BRIEF.md
# Hard-Decision Add-Compare-Select Array for Rate-1/2 Convolutional Codes

This block performs the per-symbol survivor update of a Viterbi decoder for a rate-1/2 convolutional code with hard-decision input. The constraint length K is a parameter between 3 and 7, so the trellis holds 2^(K-1) states. Each accepted symbol carries two received bits. The block scores these bits against the coded pair expected on every trellis branch. It then adds that branch cost to the stored path metric of each predecessor and keeps the cheaper candidate for every successor state. All states are updated in the same clock step.

For each step the block produces two results for a downstream traceback unit: one survivor decision bit per state, and the index of the state with the smallest metric. The stored metrics are renormalised on every step by subtracting the smallest new metric. Because of this they stay bounded for an unlimited stream.

The two generator polynomials are parameters. When they are left at their defaults, they are taken from a built-in table of common codes for the chosen K, such as octal 7/5 for K=3 and 171/133 for K=7. A polynomial bit at position K-1 taps the newest input bit, and bit 0 taps the oldest.

Top module: `acs_array`

## Requirements
- R1: Each clock edge with `sym_valid` high updates all 2^(K-1) states at once. `dec_valid` is high for exactly the cycle after each such edge and low otherwise.
- R2: After reset, state 0 holds metric 0 and every other state holds 2^(MW-2). While reset is held, `dec_valid`, `decisions` and `best_state` read 0.
- R3: After each step the smallest stored metric is 0, and no stored metric reaches 2^(MW-1), for any stream length.
- R4: The branch cost is the Hamming distance (0, 1 or 2) between the received bits and the expected pair. `rx_bits[0]` is compared with the output of polynomial A and `rx_bits[1]` with the output of polynomial B. The encoder register is {input bit, source state}, with the source state's bit 0 as the oldest bit.
- R5: Source states 2n and 2n+1 feed destinations n (input 0) and n+2^(K-2) (input 1). `decisions[d]` is 1 when the survivor of destination d comes from the odd source 2n+1, and 0 when it comes from the even source 2n.
- R6: When both candidates for a destination have equal metrics, the even source survives and the decision bit is 0.
- R7: `best_state` is the index of the smallest new metric. When several states tie, the lowest index among them is reported.
- R8: Cycles with `sym_valid` low leave `decisions` and `best_state` unchanged and ignore `rx_bits`.
- R9: For an error-free coded stream that starts from reset, `best_state` equals the encoder's state after every symbol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sym_valid | input | 1 | A received symbol is present this cycle |
| rx_bits | input | 2 | Hard-decision received pair: bit 0 for polynomial A, bit 1 for polynomial B |
| dec_valid | output | 1 | `decisions` and `best_state` hold a new step result |
| decisions | output | 2^(K-1) | One survivor decision bit per destination state |
| best_state | output | K-1 | Index of the lowest-metric state after the step |

## Verification
An error-free encoded stream shows that the branch wiring and the polynomial taps are correct, because the reported best state must follow the encoder's own state symbol by symbol. Streams with sparse random bit flips make the candidate comparisons close, and they separate a correct decision bit from a swapped or mis-wired predecessor. Constant pairs (all ones) and alternating pairs produce many equal candidates and many tied minima. These patterns expose the tie rules for the even predecessor and the lowest index. A long noisy run, a reset in the middle of the stream, and idle cycles with the received bits toggling cover metric renormalisation, the reset metric pattern, and the hold behaviour.

// File: rtl/acs_pkg.sv
package acs_pkg;

  // Default generator taps per constraint length (bit K-1 = newest input).
  function automatic int dflt_poly(input int k, input int sel);
    int a;
    int b;
    case (k)
      3:       begin a = 'o7;   b = 'o5;   end
      4:       begin a = 'o15;  b = 'o17;  end
      5:       begin a = 'o23;  b = 'o35;  end
      6:       begin a = 'o53;  b = 'o75;  end
      default: begin a = 'o171; b = 'o133; end
    endcase
    return (sel == 0) ? a : b;
  endfunction

endpackage

// File: rtl/acs_bmu.sv
// Branch cost for one fixed trellis branch: Hamming distance between the
// received pair and the coded pair that branch is expected to emit.
module acs_bmu #(
  parameter int K    = 7,
  parameter int GA   = 'o171,
  parameter int GB   = 'o133,
  parameter int REGV = 0
) (
  input  logic [1:0] rx,
  output logic [1:0] bm
);
  localparam logic [K-1:0] TAP_A = GA[K-1:0];
  localparam logic [K-1:0] TAP_B = GB[K-1:0];
  localparam logic [K-1:0] ENC   = REGV[K-1:0];
  localparam logic EXP_A = ^(TAP_A & ENC);
  localparam logic EXP_B = ^(TAP_B & ENC);

  always_comb begin
    bm = {1'b0, rx[0] ^ EXP_A} + {1'b0, rx[1] ^ EXP_B};
  end
endmodule

// File: rtl/acs_butterfly.sv
// One butterfly: sources 2N and 2N+1 feed destinations N and N+HALF.
module acs_butterfly #(
  parameter int K  = 7,
  parameter int MW = 8,
  parameter int GA = 'o171,
  parameter int GB = 'o133,
  parameter int N  = 0
) (
  input  logic [MW-1:0]       pm_even,
  input  logic [MW-1:0]       pm_odd,
  input  logic [1:0]          rx,
  output logic [1:0][MW:0]    cand,
  output logic [1:0]          dec
);
  localparam int HALF = 1 << (K - 2);

  logic [1:0]  bm  [2][2];
  logic [MW:0] sum [2][2];

  for (genvar h = 0; h < 2; h++) begin : g_dst
    // destination index N + h*HALF; encoder register = {dest, source lsb}
    for (genvar p = 0; p < 2; p++) begin : g_src
      acs_bmu #(
        .K(K), .GA(GA), .GB(GB),
        .REGV(((N + h * HALF) << 1) | p)
      ) u_bmu (
        .rx(rx),
        .bm(bm[h][p])
      );
      assign sum[h][p] = {1'b0, (p == 0) ? pm_even : pm_odd} + (MW+1)'(bm[h][p]);
    end
    // strict less-than: equal candidates keep the even source
    assign dec[h]  = sum[h][1] < sum[h][0];
    assign cand[h] = dec[h] ? sum[h][1] : sum[h][0];
  end
endmodule

// File: rtl/acs_minfind.sv
// Balanced compare tree returning the minimum and its lowest index.
module acs_minfind #(
  parameter int NS = 64,
  parameter int W  = 9,
  parameter int IW = $clog2(NS)
) (
  input  logic [NS-1:0][W-1:0] vals,
  output logic [W-1:0]         min_val,
  output logic [IW-1:0]        min_idx
);
  // heap layout: node j has children 2j and 2j+1, leaves at NS..2NS-1
  logic [W-1:0]  nv [2*NS-1:1];
  logic [IW-1:0] ni [2*NS-1:1];

  for (genvar i = 0; i < NS; i++) begin : g_leaf
    assign nv[NS+i] = vals[i];
    assign ni[NS+i] = IW'(i);
  end

  for (genvar j = 1; j < NS; j++) begin : g_node
    logic take_r;
    // right child wins only when strictly smaller: left holds lower indices
    assign take_r = nv[2*j+1] < nv[2*j];
    assign nv[j]  = take_r ? nv[2*j+1] : nv[2*j];
    assign ni[j]  = take_r ? ni[2*j+1] : ni[2*j];
  end

  assign min_val = nv[1];
  assign min_idx = ni[1];
endmodule

// File: rtl/acs_array.sv
module acs_array #(
  parameter int K  = 7,
  parameter int MW = 8,
  parameter int GA = acs_pkg::dflt_poly(K, 0),
  parameter int GB = acs_pkg::dflt_poly(K, 1),
  localparam int NS = 1 << (K - 1),
  localparam int SW = K - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sym_valid,
  input  logic [1:0]    rx_bits,
  output logic          dec_valid,
  output logic [NS-1:0] decisions,
  output logic [SW-1:0] best_state
);
  localparam int HALF  = NS / 2;
  localparam int LIMIT = 1 << (MW - 1);
  localparam logic [MW-1:0] INIT_PM = {2'b01, {(MW-2){1'b0}}};

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [MW-1:0]         pm_q [NS];
  logic [MW-1:0]         pm_d [NS];
  logic [NS-1:0][MW:0]   cand_all;
  logic [NS-1:0]         dec_all;
  logic [MW:0]           min_val;
  logic [SW-1:0]         min_idx;
  logic [NS-1:0]         dec_q;
  logic [SW-1:0]         best_q;
  logic                  vld_q;

  for (genvar n = 0; n < HALF; n++) begin : g_bfly
    logic [1:0][MW:0] bf_cand;
    logic [1:0]       bf_dec;
    acs_butterfly #(.K(K), .MW(MW), .GA(GA), .GB(GB), .N(n)) u_bfly (
      .pm_even(pm_q[2*n]),
      .pm_odd (pm_q[2*n+1]),
      .rx     (rx_bits),
      .cand   (bf_cand),
      .dec    (bf_dec)
    );
    assign cand_all[n]      = bf_cand[0];
    assign cand_all[n+HALF] = bf_cand[1];
    assign dec_all[n]       = bf_dec[0];
    assign dec_all[n+HALF]  = bf_dec[1];
  end

  acs_minfind #(.NS(NS), .W(MW+1), .IW(SW)) u_min (
    .vals   (cand_all),
    .min_val(min_val),
    .min_idx(min_idx)
  );

  // next-state: renormalise against the smallest new metric
  always_comb begin
    for (int i = 0; i < NS; i++) begin
      pm_d[i] = MW'(cand_all[i] - min_val);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int i = 0; i < NS; i++) begin
        pm_q[i] <= (i == 0) ? '0 : INIT_PM;
      end
      dec_q  <= '0;
      best_q <= '0;
    end else if (sym_valid) begin
      for (int i = 0; i < NS; i++) begin
        pm_q[i] <= pm_d[i];
      end
      dec_q  <= dec_all;
      best_q <= min_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) vld_q <= 1'b0;
    else             vld_q <= sym_valid;
  end

  assign dec_valid  = vld_q;
  assign decisions  = dec_q;
  assign best_state = best_q;

  // R1: one result pulse per accepted symbol
  p_pulse_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sym_valid |=> dec_valid);

  // R8: idle cycles produce no pulse and leave results untouched
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sym_valid |=> (!dec_valid && $stable(decisions) && $stable(best_state)));

  // R3: the reported best state carries the zero metric after a step
  p_norm_zero_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dec_valid |-> (pm_q[best_state] == '0));

  for (genvar i = 0; i < NS; i++) begin : g_chk
    // R3: renormalised metric stays below the overflow limit
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      sym_valid |-> ((cand_all[i] - min_val) < (MW+1)'(LIMIT)));
    // R7: tree minimum bounds every candidate
    p_min_bound_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
      sym_valid |-> (cand_all[i] >= min_val));
    // R7: a state equal to the minimum is never below the reported index
    p_first_min_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (sym_valid && cand_all[i] == min_val) |-> (min_idx <= SW'(i)));
  end
endmodule

// File: tb/acs_array_tb.sv
module acs_array_tb;
  localparam int CLK_P = 10;
  localparam int K     = 7;
  localparam int MW    = 8;
  localparam int NS    = 1 << (K - 1);
  localparam int TA    = 'o171;
  localparam int TB    = 'o133;
  localparam int INIT  = 1 << (MW - 2);

  typedef struct {
    logic [NS-1:0] dec;
    int            best;
    bit            chk_enc;
    int            enc;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sym_valid = 1'b0;
  logic [1:0]    rx_bits = 2'b00;
  logic          dec_valid;
  logic [NS-1:0] decisions;
  logic [K-2:0]  best_state;

  int   checks = 0;
  int   errors = 0;
  int   m_pm [NS];
  int   enc_st = 0;
  int   lfsr = 32'h2f6b_91c3;
  bit   finished = 0;
  exp_t sb [$];

  always #(CLK_P/2) clk = ~clk;

  acs_array #(.K(K), .MW(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .rx_bits(rx_bits),
    .dec_valid(dec_valid), .decisions(decisions), .best_state(best_state)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >>> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr & 32'h7fff_ffff;
  endfunction

  function automatic bit par(input int v);
    return bit'($countones(v) % 2);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NS; i++) m_pm[i] = (i == 0) ? 0 : INIT;
    enc_st = 0;
  endtask

  // Forward trellis walk: each source and input bit lands on one destination.
  task automatic model_step(input logic [1:0] r, output logic [NS-1:0] dec,
                            output int best);
    int cand [NS][2];
    int nm [NS];
    int mn;
    for (int s = 0; s < NS; s++) begin
      for (int b = 0; b < 2; b++) begin
        int ereg;
        int d;
        int bm;
        ereg = (b << (K - 1)) | s;
        bm = int'(r[0] != par(TA & ereg)) + int'(r[1] != par(TB & ereg));
        d = (s >> 1) | (b << (K - 2));
        cand[d][s & 1] = m_pm[s] + bm;
      end
    end
    mn = 1 << 30;
    best = 0;
    for (int d = 0; d < NS; d++) begin
      dec[d] = cand[d][1] < cand[d][0];
      nm[d] = dec[d] ? cand[d][1] : cand[d][0];
      if (nm[d] < mn) begin
        mn = nm[d];
        best = d;
      end
    end
    for (int d = 0; d < NS; d++) m_pm[d] = nm[d] - mn;
  endtask

  task automatic send(input logic [1:0] r, input bit chk_enc);
    exp_t it;
    @(negedge clk);
    model_step(r, it.dec, it.best);
    it.chk_enc = chk_enc;
    it.enc = enc_st;
    sb.push_back(it);
    sym_valid = 1'b1;
    rx_bits = r;
  endtask

  task automatic encode(input bit b, output logic [1:0] r);
    int ereg;
    ereg = (b << (K - 1)) | enc_st;
    r[0] = par(TA & ereg);
    r[1] = par(TB & ereg);
    enc_st = (enc_st >> 1) | (int'(b) << (K - 2));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sym_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    sym_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R2: outputs cleared while reset is held
    chk("R2", "dec_valid in reset", 64'(dec_valid), 64'd0);
    chk("R2", "decisions in reset", 64'(decisions), 64'd0);
    chk("R2", "best_state in reset", 64'(best_state), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: pop one expected item per result pulse
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && dec_valid) begin
        if (sb.size() == 0) begin
          chk("R1", "unexpected dec_valid", 64'd1, 64'd0);
        end else begin
          exp_t it;
          it = sb.pop_front();
          chk("R4 R5 R6", "decisions", 64'(decisions), 64'(it.dec));
          chk("R7", "best_state", 64'(best_state), 64'(it.best));
          if (it.chk_enc)
            chk("R9", "best_state vs encoder", 64'(best_state), 64'(it.enc));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [1:0] r;
    logic [NS-1:0] hold_dec;
    logic [K-2:0]  hold_best;
    do_reset();

    // R2: first symbol after reset sees state 0 at 0, others at INIT
    send(2'b00, 1'b1);
    idle(2);
    chk("R1", "queue drained", 64'(sb.size()), 64'd0);

    // R9: error-free coded stream from reset
    do_reset();
    for (int i = 0; i < 40; i++) begin
      encode(bit'(rnd() & 1), r);
      send(r, 1'b1);
    end
    idle(2);

    // R8: idle with toggling inputs leaves results untouched
    hold_dec = decisions;
    hold_best = best_state;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      rx_bits = 2'(i);
      chk("R8", "dec_valid idle", 64'(dec_valid), 64'd0);
      chk("R8", "decisions idle", 64'(decisions), 64'(hold_dec));
      chk("R8", "best_state idle", 64'(best_state), 64'(hold_best));
    end

    // R4 R5: noisy coded stream with sparse flips
    for (int i = 0; i < 80; i++) begin
      encode(bit'(rnd() & 1), r);
      if ((rnd() & 7) == 0) r[0] = ~r[0];
      if ((rnd() & 7) == 0) r[1] = ~r[1];
      send(r, 1'b0);
    end

    // R6 R7: constant and alternating pairs give many ties
    do_reset();
    for (int i = 0; i < 16; i++) send(2'b11, 1'b0);
    for (int i = 0; i < 16; i++) send((i % 2) ? 2'b01 : 2'b10, 1'b0);
    idle(2);
    chk("R1", "queue drained after ties", 64'(sb.size()), 64'd0);

    // R3: long noisy run exercises renormalisation; R2 mid-stream reset first
    do_reset();
    for (int i = 0; i < 400; i++) begin
      encode(bit'(rnd() & 1), r);
      if ((rnd() % 5) == 0) r[rnd() & 1] = ~r[rnd() & 1];
      send(r, 1'b0);
    end
    // R3: random raw pairs, no code structure at all
    for (int i = 0; i < 100; i++) send(2'(rnd()), 1'b0);
    idle(3);
    chk("R1", "queue drained at end", 64'(sb.size()), 64'd0);
    finish_run();
  end
endmodule